// File: doc/BRIEF.md
# Interrupt, Halt and Reset Controller for a Dual-Master Serial Bus Engine

This block collects completion and error events from two serial-bus masters, each of which runs two command queues. It records them in one 32-bit status word, and it drives a single interrupt line through a programmable enable mask. Software clears status bits by writing ones to a clear register. The interrupt line is latched: once it rises, it stays high until software issues a global clear command. That command re-arms the line and lowers it only when no enabled status bit is still pending.

The block also runs the recovery handshake after a bus error. A halt request stops both queues of the selected master. After a fixed latency the block sets that master's halt-acknowledge bit. Software then writes a reset command whose bit fields select one master or the whole controller. The block pulses reset to the chosen masters for a fixed number of cycles, releases their halt, and sets the reset-done bit. Every acknowledge travels through the same status word and interrupt line as the ordinary events.

Register selects on `bus_addr`: 0 status (read only), 1 interrupt enable mask (read/write), 2 clear, 3 global clear, 4 halt request, 5 reset command. Reads from other selects return zero.

Top module: `irqhr_top`

## Requirements
- R1: After reset, the status word, the mask, `irq`, `q_halt` and `mst_reset` are all zero.
- R2: The event bits in the status word are placed as follows. For master 0: read-done at bit 0, queue 0 report at bit 4 and queue 1 report at bit 8. Master 1 uses the same positions plus 12. Each event input pulse sets its bit at the next clock edge.
- R3: Fault input bit k of master m (`ev_fault[8m+k]`) sets status bit 12m + {1,2,5,6,7,9,10,11}[k]. NACK input `ev_nack[2m+q]` sets bit 27 + 2m + q. All error bits of master 0 together form 0x18000EE6, and those of master 1 form 0x60EE6000.
- R4: A write to the clear register clears every status bit written as 1. If an event sets a bit in the same cycle as a clear, the bit stays set.
- R5: `irq` rises one cycle after an event sets a status bit that is enabled in the mask. Status bits that are not enabled do not raise it.
- R6: `irq` falls only at a global clear write with data bit 0 set. That write lowers it only if no enabled status bit remains set afterwards. Clearing status bits alone leaves `irq` high.
- R7: Halt request data bit m stops both queues of master m (`q_halt[2m+1:2m]`) from the next cycle on. Halt-acknowledge bit 25 + m is set 4 clock edges after the write edge.
- R8: While a master's queues are stopped, that master's event, fault and NACK inputs are ignored. The other master's inputs are still recorded.
- R9: A halt request for a master that is already halting or halted produces no second acknowledge.
- R10: A reset command whose data contains all bits of 0x3F1 resets master 0, and one containing all bits of 0x3F001 resets master 1. `mst_reset` is high for the selected masters for 4 cycles. When it ends, the selected halts are released and reset-done bit 24 is set.
- R11: A reset command containing all bits of 0x0F73F3F7 resets both masters. On completion it clears every status bit except the bits set in that same cycle, including reset-done.
- R12: A reset command matching neither master field is ignored. A reset command written while a reset is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected register (combinational) |
| ev_rd_done | input | 2 | Read-done pulse, one per master |
| ev_report | input | 4 | Queue report pulse, index 2*master+queue |
| ev_nack | input | 4 | NACK error pulse, index 2*master+queue |
| ev_fault | input | 16 | Other error pulses, 8 per master |
| irq | output | 1 | Latched interrupt line |
| q_halt | output | 4 | Queue stop, index 2*master+queue |
| mst_reset | output | 2 | Reset to each master while a reset runs |

## Verification
Suppose a halt counter is stuck or loaded with the wrong value. The acknowledge bit then appears a cycle early or late, or never, so the bench samples the status word one cycle before and exactly at the expected edge. A wrong latch in the interrupt path shows as `irq` falling after a status clear with no global clear, or staying high after a global clear with nothing pending. Both are visible one cycle after the write. A wrong reset-field decode shows at once on `mst_reset` in the cycle after the command, and four cycles later as a halt that is not released or a status word that was not wiped.

// File: rtl/irqhr_pkg.sv
// Shared constants and event-to-status mapping for the interrupt/halt/reset controller.
// Assumes exactly two masters with two queues each; the bit map is fixed.
package irqhr_pkg;
    localparam int DW         = 32;
    localparam int NMST       = 2;
    localparam int NQ         = 2;
    localparam int FLT_W      = 8;
    localparam int ADDR_W     = 3;

    localparam int RD_BIT     = 0;
    localparam int REP_BIT    = 4;
    localparam int Q_STRIDE   = 4;
    localparam int MST_STRIDE = 12;
    localparam int RDONE_BIT  = 24;
    localparam int HACK_BASE  = 25;
    localparam int NACK_BASE  = 27;

    localparam logic [DW-1:0] RST_ALL = 32'h0F73F3F7;
    localparam logic [DW-1:0] RST_M0  = 32'h000003F1;
    localparam logic [DW-1:0] RST_M1  = 32'h0003F001;

    localparam logic [ADDR_W-1:0] SEL_STATUS = 3'd0;
    localparam logic [ADDR_W-1:0] SEL_MASK   = 3'd1;
    localparam logic [ADDR_W-1:0] SEL_CLEAR  = 3'd2;
    localparam logic [ADDR_W-1:0] SEL_GCLR   = 3'd3;
    localparam logic [ADDR_W-1:0] SEL_HALT   = 3'd4;
    localparam logic [ADDR_W-1:0] SEL_RESET  = 3'd5;

    // Offset of fault k inside a master's 12-bit field.
    function automatic int fault_pos(input int k);
        if (k < 2)      return 1 + k;
        else if (k < 5) return 5 + (k - 2);
        else            return 9 + (k - 5);
    endfunction

    // Build the status bits contributed by one master's event inputs.
    function automatic logic [DW-1:0] master_events(input int m, input logic rd,
                                                     input logic [NQ-1:0] rep,
                                                     input logic [NQ-1:0] nack,
                                                     input logic [FLT_W-1:0] flt);
        logic [DW-1:0] w;
        w = '0;
        w[m*MST_STRIDE + RD_BIT] = rd;
        for (int q = 0; q < NQ; q++) begin
            w[m*MST_STRIDE + REP_BIT + q*Q_STRIDE] = rep[q];
            w[NACK_BASE + m*NQ + q]                = nack[q];
        end
        for (int k = 0; k < FLT_W; k++)
            w[m*MST_STRIDE + fault_pos(k)] = flt[k];
        return w;
    endfunction
endpackage

// File: rtl/irqhr_status.sv
// Status word, enable mask and latched interrupt line.
// Assumes set_vec and clr_vec are single-cycle; set wins over clear.
module irqhr_status
    import irqhr_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] set_vec,
    input  logic [DW-1:0] clr_vec,
    input  logic          clr_all,
    input  logic          mask_we,
    input  logic [DW-1:0] mask_wdata,
    input  logic          gclr,
    output logic [DW-1:0] status,
    output logic [DW-1:0] mask,
    output logic          irq
);
    logic [DW-1:0] status_n;
    logic [DW-1:0] mask_n;

    // Next status: clear (or wipe) first, then OR in new events.
    always_comb begin
        status_n = clr_all ? set_vec : ((status & ~clr_vec) | set_vec);
        mask_n   = mask_we ? mask_wdata : mask;
    end

    // Register status, mask and the interrupt latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
            mask   <= '0;
            irq    <= 1'b0;
        end else begin
            status <= status_n;
            mask   <= mask_n;
            irq    <= (irq & ~gclr) | (|(status_n & mask_n));
        end
    end
endmodule

// File: rtl/irqhr_halt.sv
// Per-master halt handshake: stops both queues, acknowledges after LAT cycles,
// stays halted until the reset engine releases it. Assumes LAT >= 1.
module irqhr_halt #(
    parameter int LAT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic block,
    input  logic release_i,
    output logic stopped,
    output logic ack
);
    localparam int CW = $clog2(LAT + 1);

    logic [CW-1:0] cnt;
    logic          halted;

    // Acknowledge on the last count, unless a release lands in the same cycle.
    always_comb begin
        ack     = (cnt == CW'(1)) && !release_i;
        stopped = halted || (cnt != '0);
    end

    // Count the halt latency and hold the halted state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            halted <= 1'b0;
        end else if (release_i) begin
            cnt    <= '0;
            halted <= 1'b0;
        end else begin
            if (req && !block && !stopped)
                cnt <= CW'(LAT);
            else if (cnt != '0)
                cnt <= cnt - 1'b1;
            if (ack)
                halted <= 1'b1;
        end
    end
endmodule

// File: rtl/irqhr_reset.sv
// Shared reset engine: decodes per-master fields of a reset command, holds the
// selected reset lines for LAT cycles and signals completion. Assumes LAT >= 1.
module irqhr_reset
    import irqhr_pkg::*;
#(
    parameter int LAT = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_we,
    input  logic [DW-1:0]   cmd_data,
    output logic            busy,
    output logic [NMST-1:0] sel,
    output logic            done,
    output logic            full_done
);
    localparam int CW = $clog2(LAT + 1);

    logic [CW-1:0]   cnt;
    logic            full_q;
    logic [NMST-1:0] hit;
    logic            accept;

    // Decode which master fields the command covers.
    always_comb begin
        hit[0]    = (cmd_data & RST_M0) == RST_M0;
        hit[1]    = (cmd_data & RST_M1) == RST_M1;
        busy      = cnt != '0;
        accept    = cmd_we && !busy && (|hit);
        done      = cnt == CW'(1);
        full_done = done && full_q;
    end

    // Start, count down and retire a reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            sel    <= '0;
            full_q <= 1'b0;
        end else if (accept) begin
            cnt    <= CW'(LAT);
            sel    <= hit;
            full_q <= (cmd_data & RST_ALL) == RST_ALL;
        end else if (busy) begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/irqhr_top.sv
// Interrupt, halt and reset controller for two bus masters.
// Decodes register writes, gates events of halted masters and merges all
// events and acknowledges into one status word. Assumes one write per cycle.
module irqhr_top
    import irqhr_pkg::*;
#(
    parameter int HALT_LAT = 4,
    parameter int RST_LAT  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DW-1:0]       bus_wdata,
    output logic [DW-1:0]       bus_rdata,
    input  logic [NMST-1:0]     ev_rd_done,
    input  logic [NMST*NQ-1:0]  ev_report,
    input  logic [NMST*NQ-1:0]  ev_nack,
    input  logic [NMST*FLT_W-1:0] ev_fault,
    output logic                irq,
    output logic [NMST*NQ-1:0]  q_halt,
    output logic [NMST-1:0]     mst_reset
);
    logic [DW-1:0]   stat_word;
    logic [DW-1:0]   mask_word;
    logic [DW-1:0]   clr_vec;
    logic [DW-1:0]   set_vec;
    logic            gclr;
    logic            mask_we;
    logic            rst_we;
    logic            rst_busy;
    logic            rst_done;
    logic            rst_full;
    logic [NMST-1:0] rst_sel;
    logic [NMST-1:0] stopped;
    logic [NMST-1:0] hack;
    logic [DW-1:0]   ev_word [NMST];

    // Decode register writes into strobes.
    always_comb begin
        mask_we = bus_wr && (bus_addr == SEL_MASK);
        clr_vec = (bus_wr && (bus_addr == SEL_CLEAR)) ? bus_wdata : '0;
        gclr    = bus_wr && (bus_addr == SEL_GCLR) && bus_wdata[0];
        rst_we  = bus_wr && (bus_addr == SEL_RESET);
    end

    // Read mux: only status and mask are readable.
    always_comb begin
        case (bus_addr)
            SEL_STATUS: bus_rdata = stat_word;
            SEL_MASK:   bus_rdata = mask_word;
            default:    bus_rdata = '0;
        endcase
    end

    irqhr_reset #(.LAT(RST_LAT)) u_reset (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_we    (rst_we),
        .cmd_data  (bus_wdata),
        .busy      (rst_busy),
        .sel       (rst_sel),
        .done      (rst_done),
        .full_done (rst_full)
    );

    for (genvar m = 0; m < NMST; m++) begin : g_mst
        irqhr_halt #(.LAT(HALT_LAT)) u_halt (
            .clk       (clk),
            .rst_n     (rst_n),
            .req       (bus_wr && (bus_addr == SEL_HALT) && bus_wdata[m]),
            .block     (rst_busy && rst_sel[m]),
            .release_i (rst_done && rst_sel[m]),
            .stopped   (stopped[m]),
            .ack       (hack[m])
        );

        // Map this master's inputs to status bits; drop them while stopped.
        always_comb begin
            ev_word[m] = stopped[m] ? '0 :
                master_events(m, ev_rd_done[m], ev_report[m*NQ +: NQ],
                              ev_nack[m*NQ +: NQ], ev_fault[m*FLT_W +: FLT_W]);
        end

        assign q_halt[m*NQ +: NQ] = {NQ{stopped[m]}};
        assign mst_reset[m]       = rst_busy && rst_sel[m];
    end

    // Merge events, halt acknowledges and reset completion.
    always_comb begin
        set_vec = '0;
        for (int m = 0; m < NMST; m++) begin
            set_vec = set_vec | ev_word[m];
            set_vec[HACK_BASE + m] = hack[m];
        end
        set_vec[RDONE_BIT] = rst_done;
    end

    irqhr_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_vec    (set_vec),
        .clr_vec    (clr_vec),
        .clr_all    (rst_full),
        .mask_we    (mask_we),
        .mask_wdata (bus_wdata),
        .gclr       (gclr),
        .status     (stat_word),
        .mask       (mask_word),
        .irq        (irq)
    );
endmodule

// File: rtl/irqhr_checker.sv
// Temporal checks on the controller, bound to irqhr_top.
module irqhr_checker
    import irqhr_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [DW-1:0]       bus_wdata,
    input logic                irq,
    input logic [NMST*NQ-1:0]  q_halt,
    input logic [NMST-1:0]     mst_reset,
    input logic [DW-1:0]       status
);
    logic gclr_seen;
    assign gclr_seen = bus_wr && (bus_addr == SEL_GCLR) && bus_wdata[0];

    // R6: the line only drops on a global clear command
    assert_irq_fall_gclr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(gclr_seen));

    // R7: a master 0 halt acknowledge appears only while its queues are stopped
    assert_hack_halted_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[HACK_BASE]) |-> (q_halt[1:0] == 2'b11));

    // R10: reset-done follows an active reset window
    assert_rdone_after_rst_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[RDONE_BIT]) |-> $past(mst_reset != '0));

    // R10: a halt is released only by that master's reset
    assert_halt_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q_halt[0]) |-> $past(mst_reset[0]));

    // R12: a running reset keeps its selection
    assert_rst_sel_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ((mst_reset != '0) && $past(mst_reset != '0)) |-> $stable(mst_reset));
endmodule

bind irqhr_top irqhr_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .q_halt    (q_halt),
    .mst_reset (mst_reset),
    .status    (stat_word)
);

// File: tb/tb_irqhr_top.sv
// Directed bench for irqhr_top: one task per scenario, each checking itself.
module tb_irqhr_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  ev_rd_done = '0;
    logic [3:0]  ev_report = '0;
    logic [3:0]  ev_nack = '0;
    logic [15:0] ev_fault = '0;
    logic        irq;
    logic [3:0]  q_halt;
    logic [1:0]  mst_reset;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    irqhr_top dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_rd_done(ev_rd_done),
        .ev_report(ev_report), .ev_nack(ev_nack), .ev_fault(ev_fault),
        .irq(irq), .q_halt(q_halt), .mst_reset(mst_reset)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_status(output logic [31:0] d);
        bus_addr = 3'd0;
        #1 d = bus_rdata;
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic [1:0] rd, input logic [3:0] rep,
                         input logic [3:0] nk, input logic [15:0] flt);
        @(negedge clk);
        ev_rd_done = rd; ev_report = rep; ev_nack = nk; ev_fault = flt;
        @(negedge clk);
        ev_rd_done = '0; ev_report = '0; ev_nack = '0; ev_fault = '0;
    endtask

    task automatic t_reset_state;
        logic [31:0] s;
        rd_status(s);
        chk("R1 status", s, 0);
        bus_addr = 3'd1; #1 chk("R1 mask", bus_rdata, 0);
        chk("R1 irq", {31'd0, irq}, 0);
        chk("R1 q_halt", {28'd0, q_halt}, 0);
        chk("R1 mst_reset", {30'd0, mst_reset}, 0);
    endtask

    task automatic t_events;
        logic [31:0] s;
        pulse(2'b01, 4'b0010, 4'b0000, 16'h0);
        rd_status(s);
        chk("R2 m0 rd-done and q1 report", s, 32'h0000_0101);
        pulse(2'b10, 4'b0100, 4'b0000, 16'h0);
        rd_status(s);
        chk("R2 m1 rd-done and q0 report", s, 32'h0001_1101);
        chk("R5 masked-off bits leave irq low", {31'd0, irq}, 0);
        wr(3'd2, 32'hFFFF_FFFF);
        rd_status(s);
        chk("R4 clear all", s, 0);
    endtask

    task automatic t_errors;
        logic [31:0] s;
        pulse(2'b00, 4'b0000, 4'b0011, 16'h00FF);
        rd_status(s);
        chk("R3 m0 error set", s, 32'h1800_0EE6);
        wr(3'd2, 32'hFFFF_FFFF);
        pulse(2'b00, 4'b0000, 4'b1100, 16'hFF00);
        rd_status(s);
        chk("R3 m1 error set", s, 32'h60EE_6000);
        wr(3'd2, 32'h0000_6000);
        rd_status(s);
        chk("R4 partial clear", s, 32'h60EE_0000);
        wr(3'd2, 32'hFFFF_FFFF);
    endtask

    task automatic t_set_wins;
        logic [31:0] s;
        pulse(2'b10, 4'b0000, 4'b0000, 16'h0);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 3'd2; bus_wdata = 32'h0000_1001;
        ev_rd_done = 2'b01;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0; ev_rd_done = '0;
        rd_status(s);
        chk("R4 set wins over same-cycle clear", s, 32'h0000_0001);
        wr(3'd2, 32'hFFFF_FFFF);
    endtask

    task automatic t_irq;
        wr(3'd1, 32'h0000_0001);
        pulse(2'b01, 4'b0000, 4'b0000, 16'h0);
        chk("R5 irq rises on enabled event", {31'd0, irq}, 1);
        wr(3'd2, 32'h0000_0001);
        chk("R6 irq held after status clear", {31'd0, irq}, 1);
        wr(3'd3, 32'h0000_0001);
        chk("R6 global clear drops irq", {31'd0, irq}, 0);
        pulse(2'b01, 4'b0000, 4'b0000, 16'h0);
        wr(3'd3, 32'h0000_0001);
        chk("R6 global clear with pending keeps irq", {31'd0, irq}, 1);
        wr(3'd2, 32'hFFFF_FFFF);
        wr(3'd3, 32'h0000_0001);
        chk("R6 irq low after clear and re-arm", {31'd0, irq}, 0);
        wr(3'd1, 32'h0);
    endtask

    task automatic t_halt;
        logic [31:0] s;
        wr(3'd4, 32'h1);
        chk("R7 both m0 queues stopped", {28'd0, q_halt}, 32'h3);
        waitn(3);
        rd_status(s);
        chk("R7 no ack one cycle early", s, 0);
        waitn(1);
        rd_status(s);
        chk("R7 ack at 4th edge", s, 32'h0200_0000);
        pulse(2'b11, 4'b0000, 4'b0000, 16'h0);
        rd_status(s);
        chk("R8 halted m0 ignored, m1 recorded", s, 32'h0200_1000);
        wr(3'd2, 32'hFFFF_FFFF);
        wr(3'd4, 32'h1);
        waitn(6);
        rd_status(s);
        chk("R9 repeat halt gives no ack", s, 0);
        chk("R9 queues remain stopped", {28'd0, q_halt}, 32'h3);
    endtask

    task automatic t_reset_masters;
        logic [31:0] s;
        wr(3'd4, 32'h2);
        waitn(4);
        wr(3'd2, 32'hFFFF_FFFF);
        wr(3'd5, 32'h0000_03F1);
        chk("R10 m0 reset line", {30'd0, mst_reset}, 1);
        waitn(3);
        chk("R10 m0 reset still held", {30'd0, mst_reset}, 1);
        waitn(1);
        chk("R10 m0 reset ends", {30'd0, mst_reset}, 0);
        rd_status(s);
        chk("R10 reset-done set", s, 32'h0100_0000);
        chk("R10 only m0 released", {28'd0, q_halt}, 32'hC);
        wr(3'd2, 32'hFFFF_FFFF);
        wr(3'd5, 32'h0003_F001);
        chk("R10 m1 reset line", {30'd0, mst_reset}, 2);
        waitn(4);
        chk("R10 m1 released", {28'd0, q_halt}, 0);
        wr(3'd2, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset_ignored;
        logic [31:0] s;
        wr(3'd5, 32'h0000_00F0);
        chk("R12 unmatched command ignored", {30'd0, mst_reset}, 0);
        waitn(5);
        rd_status(s);
        chk("R12 no reset-done", s, 0);
        wr(3'd5, 32'h0000_03F1);
        wr(3'd5, 32'h0003_F001);
        chk("R12 busy command ignored", {30'd0, mst_reset}, 1);
        waitn(4);
        chk("R12 no second reset", {30'd0, mst_reset}, 0);
        wr(3'd2, 32'hFFFF_FFFF);
    endtask

    task automatic t_full_reset;
        logic [31:0] s;
        pulse(2'b01, 4'b0000, 4'b0100, 16'h0);
        wr(3'd5, 32'h0F73_F3F7);
        chk("R11 both masters reset", {30'd0, mst_reset}, 3);
        waitn(4);
        rd_status(s);
        chk("R11 status wiped but reset-done", s, 32'h0100_0000);
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_events();
        t_errors();
        t_set_wins();
        t_irq();
        t_halt();
        t_reset_masters();
        t_reset_ignored();
        t_full_reset();
        finish_run();
    end
endmodule